// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block is the register file and transfer bookkeeping of the DMA channel inside a SCSI host adapter. Software programs a start count, a start address and a start descriptor address through a word-indexed register port, then issues a command. A start command copies the start values into a working set and enables DMA toward the SCSI core. After that the core reports each data movement on a transfer-request port. The block accepts the request only when its direction matches the programmed direction. It clamps the length to the remaining count, then decrements the working count and advances the working address by the accepted amount.

A status register records completion, abort and error events. A global mode input selects how software clears those flags. In one mode software writes ones to clear them. In the other mode a status read clears them after returning their old value. The SCSI core interrupt is merged into the status value when it is read and is never stored. Bus mastering, descriptor-list walking and the burst-flush action are outside this block. The descriptor and diagnostic command bits are only stored.

Top module: `scsi_dma_chan`

## Requirements
- R1: Registers are selected by `reg_addr_i`: 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor address, 7 working descriptor address. Command, start count, start address and start descriptor address read back the full word last written.
- R2: A command write whose bits [1:0] equal 3 (start) copies start count, start address and start descriptor address into the working count, working address and working descriptor address. It also sets `dma_en_o`. All of this is visible after the write cycle.
- R3: A start command clears status bits [5:0].
- R4: In command bits [1:0], opcode 0 (idle) clears `dma_en_o` and opcode 1 (flush) changes neither output. Opcode 2 (abort) raises `abort_o` for exactly the one cycle that follows the write.
- R5: A transfer request whose `xfer_dir_i` differs from command bit 7 (1 = device to memory) is dropped. In that case `xfer_len_o` is 0 and the count and address do not change.
- R6: An accepted request reports `xfer_len_o` = min(`xfer_len_i`, working count). In the same cycle the working count drops by that amount and the working address rises by it.
- R7: Status bit 3 (done) is set when an accepted nonzero transfer brings the working count to 0. A request whose accepted length is 0 changes no state.
- R8: A `core_done_i` pulse forces the working count to 0 and sets done.
- R9: With `stat_w1c_i` = 1, a status write clears those of bits 1 (error), 2 (abort) and 3 (done) that are written as 1. A status read clears nothing.
- R10: With `stat_w1c_i` = 0, a status write has no effect. A status read returns the current bits and then clears bits 1, 2 and 3.
- R11: Status bit 4 reads as `core_irq_i` at the time of the read and is not held.
- R12: Writes to the working count, working address and working descriptor address are ignored.
- R13: After reset the command, working count and status read 0, the working address reads all ones, the working descriptor address reads all ones except bit 1 (0xFFFFFFFD), and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (drives read side effects) |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, combinational |
| stat_w1c_i | input | 1 | Status clear mode: 1 write-one-to-clear, 0 clear-on-read |
| xfer_req_i | input | 1 | Transfer request from the SCSI core |
| xfer_dir_i | input | 1 | Requested direction, 1 = device to memory |
| xfer_len_i | input | LEN_W | Requested length |
| xfer_len_o | output | LEN_W | Accepted, clamped length, combinational |
| core_done_i | input | 1 | Core command completion pulse |
| core_irq_i | input | 1 | Core interrupt level |
| dma_en_o | output | 1 | DMA enabled toward the core |
| abort_o | output | 1 | One-cycle request to cancel the active core request |

## Verification
The bench builds the block with a 32-bit register width and an 8-bit transfer length. Every request length from 0 to 255 is then swept against working counts of 0, 1, 7, 128, 255 and 300. That sweep covers the clamp on both sides, the exact hit of zero that sets done, and the zero-length no-op. The same small build also covers both status clear modes, both directions and each opcode.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  typedef enum logic [2:0] {
    IDX_CMD  = 3'd0,
    IDX_SCNT = 3'd1,
    IDX_SADR = 3'd2,
    IDX_WCNT = 3'd3,
    IDX_WADR = 3'd4,
    IDX_STAT = 3'd5,
    IDX_SDSC = 3'd6,
    IDX_WDSC = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam int CMD_DIR_BIT = 7;
  localparam int STAT_W      = 6;
  localparam int ST_ERR      = 1;
  localparam int ST_ABT      = 2;
  localparam int ST_DONE     = 3;
  localparam int ST_IRQ      = 4;
endpackage

// File: rtl/dma_cmd_dec.sv
module dma_cmd_dec
  import scsi_dma_pkg::*;
(
  input  logic       cmd_wr_i,
  input  logic [1:0] op_i,
  output logic       do_idle_o,
  output logic       do_abort_o,
  output logic       do_start_o
);
  dma_op_e op;
  assign op = dma_op_e'(op_i);

  always_comb begin
    do_idle_o  = 1'b0;
    do_abort_o = 1'b0;
    do_start_o = 1'b0;
    if (cmd_wr_i) begin
      unique case (op)
        OP_IDLE:  do_idle_o  = 1'b1;
        OP_FLUSH: ;
        OP_ABORT: do_abort_o = 1'b1;
        OP_START: do_start_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_calc.sv
module dma_xfer_calc #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              req_i,
  input  logic              dir_i,
  input  logic              dir_sel_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] wcnt_i,
  input  logic [DATA_W-1:0] wadr_i,
  output logic              take_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] wcnt_nx_o,
  output logic [DATA_W-1:0] wadr_nx_o,
  output logic              hit_zero_o
);
  logic              accept;
  logic [LEN_W-1:0]  eff;
  logic [DATA_W-1:0] len_ext;

  assign len_ext = DATA_W'(len_i);
  assign accept  = req_i && (dir_i == dir_sel_i);

  always_comb begin
    if (wcnt_i < len_ext) eff = wcnt_i[LEN_W-1:0];
    else                  eff = len_i;
  end

  assign len_o      = accept ? eff : '0;
  assign take_o     = accept && (eff != '0);
  assign wcnt_nx_o  = wcnt_i - DATA_W'(eff);
  assign wadr_nx_o  = wadr_i + DATA_W'(eff);
  assign hit_zero_o = take_o && (wcnt_nx_o == '0);
endmodule

// File: rtl/dma_stat_reg.sv
module dma_stat_reg
  import scsi_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              set_done_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              w1c_mode_i,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [STAT_W-1:0] CLR_MASK =
    STAT_W'((1 << ST_ERR) | (1 << ST_ABT) | (1 << ST_DONE));

  logic [STAT_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (start_i) begin
      stat_d = '0;
    end else begin
      if (wr_i && w1c_mode_i)  stat_d = stat_d & ~(wdata_i & CLR_MASK);
      if (rd_i && !w1c_mode_i) stat_d = stat_d & ~CLR_MASK;
    end
    // events win over clears in the same cycle
    if (set_done_i) stat_d[ST_DONE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
  import scsi_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              stat_w1c_i,
  input  logic              xfer_req_i,
  input  logic              xfer_dir_i,
  input  logic [LEN_W-1:0]  xfer_len_i,
  output logic [LEN_W-1:0]  xfer_len_o,
  input  logic              core_done_i,
  input  logic              core_irq_i,
  output logic              dma_en_o,
  output logic              abort_o
);
  localparam logic [DATA_W-1:0] WADR_RST = '1;
  localparam logic [DATA_W-1:0] WDSC_RST = ~DATA_W'(2);

  reg_idx_e idx;
  assign idx = reg_idx_e'(reg_addr_i);

  logic [DATA_W-1:0] cmd_q, scnt_q, sadr_q, sdsc_q, wcnt_q, wadr_q, wdsc_q;
  logic              dma_en_q, abort_q;
  logic [STAT_W-1:0] stat_q;

  logic do_idle, do_abort, do_start;
  logic take, hit_zero, set_done;
  logic [DATA_W-1:0] wcnt_nx, wadr_nx;

  dma_cmd_dec i_cmd_dec (
    .cmd_wr_i   (reg_wr_i && (idx == IDX_CMD)),
    .op_i       (reg_wdata_i[1:0]),
    .do_idle_o  (do_idle),
    .do_abort_o (do_abort),
    .do_start_o (do_start)
  );

  dma_xfer_calc #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_xfer_calc (
    .req_i      (xfer_req_i),
    .dir_i      (xfer_dir_i),
    .dir_sel_i  (cmd_q[CMD_DIR_BIT]),
    .len_i      (xfer_len_i),
    .wcnt_i     (wcnt_q),
    .wadr_i     (wadr_q),
    .take_o     (take),
    .len_o      (xfer_len_o),
    .wcnt_nx_o  (wcnt_nx),
    .wadr_nx_o  (wadr_nx),
    .hit_zero_o (hit_zero)
  );

  assign set_done = !do_start && (core_done_i || hit_zero);

  dma_stat_reg i_stat_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (do_start),
    .set_done_i (set_done),
    .wr_i       (reg_wr_i && (idx == IDX_STAT)),
    .wdata_i    (reg_wdata_i[STAT_W-1:0]),
    .rd_i       (reg_rd_i && (idx == IDX_STAT)),
    .w1c_mode_i (stat_w1c_i),
    .stat_o     (stat_q)
  );

  // start-side registers, software owned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      scnt_q <= '0;
      sadr_q <= '0;
      sdsc_q <= '0;
    end else if (reg_wr_i) begin
      unique case (idx)
        IDX_CMD:  cmd_q  <= reg_wdata_i;
        IDX_SCNT: scnt_q <= reg_wdata_i;
        IDX_SADR: sadr_q <= reg_wdata_i;
        IDX_SDSC: sdsc_q <= reg_wdata_i;
        default:  ;
      endcase
    end
  end

  // working set, hardware owned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      wadr_q <= WADR_RST;
      wdsc_q <= WDSC_RST;
    end else if (do_start) begin
      wcnt_q <= scnt_q;
      wadr_q <= sadr_q;
      wdsc_q <= sdsc_q;
    end else begin
      if (core_done_i) wcnt_q <= '0;
      else if (take)   wcnt_q <= wcnt_nx;
      if (take)        wadr_q <= wadr_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_en_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= do_abort;
      if (do_start)     dma_en_q <= 1'b1;
      else if (do_idle) dma_en_q <= 1'b0;
    end
  end

  assign dma_en_o = dma_en_q;
  assign abort_o  = abort_q;

  always_comb begin
    unique case (idx)
      IDX_CMD:  reg_rdata_o = cmd_q;
      IDX_SCNT: reg_rdata_o = scnt_q;
      IDX_SADR: reg_rdata_o = sadr_q;
      IDX_WCNT: reg_rdata_o = wcnt_q;
      IDX_WADR: reg_rdata_o = wadr_q;
      IDX_STAT: begin
        reg_rdata_o = DATA_W'(stat_q);
        reg_rdata_o[ST_IRQ] = stat_q[ST_IRQ] | core_irq_i;
      end
      IDX_SDSC: reg_rdata_o = sdsc_q;
      IDX_WDSC: reg_rdata_o = wdsc_q;
    endcase
  end
endmodule

// File: rtl/scsi_dma_chan_chk.sv
module scsi_dma_chan_chk #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [2:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              xfer_req_i,
  input logic              xfer_dir_i,
  input logic [LEN_W-1:0]  xfer_len_i,
  input logic [LEN_W-1:0]  xfer_len_o,
  input logic              core_done_i,
  input logic              core_irq_i,
  input logic              dma_en_o,
  input logic              abort_o,
  input logic [DATA_W-1:0] cmd_q,
  input logic [DATA_W-1:0] scnt_q,
  input logic [DATA_W-1:0] sadr_q,
  input logic [DATA_W-1:0] wcnt_q,
  input logic [5:0]        stat_q
);
  logic wr_start, wr_abort;
  assign wr_start = reg_wr_i && (reg_addr_i == 3'd0) && (reg_wdata_i[1:0] == 2'd3);
  assign wr_abort = reg_wr_i && (reg_addr_i == 3'd0) && (reg_wdata_i[1:0] == 2'd2);

  a_r2_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start |=> (wcnt_q == $past(scnt_q)) && dma_en_o);

  a_r4_abort_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(wr_abort));

  a_r5_wrong_dir_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_i && (xfer_dir_i != cmd_q[7])) |-> (xfer_len_o == '0));

  a_r6_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_i |-> ((DATA_W'(xfer_len_o) <= wcnt_q) && (xfer_len_o <= xfer_len_i)));

  a_r8_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_done_i && !wr_start) |=> ((wcnt_q == '0) && stat_q[3]));

  a_r11_irq_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 3'd5) |-> (reg_rdata_o[4] == core_irq_i));

  a_r12_wcnt_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && (reg_addr_i == 3'd3) && !xfer_req_i && !core_done_i) |=> $stable(wcnt_q));
endmodule

bind scsi_dma_chan scsi_dma_chan_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .xfer_req_i  (xfer_req_i),
  .xfer_dir_i  (xfer_dir_i),
  .xfer_len_i  (xfer_len_i),
  .xfer_len_o  (xfer_len_o),
  .core_done_i (core_done_i),
  .core_irq_i  (core_irq_i),
  .dma_en_o    (dma_en_o),
  .abort_o     (abort_o),
  .cmd_q       (cmd_q),
  .scnt_q      (scnt_q),
  .sadr_q      (sadr_q),
  .wcnt_q      (wcnt_q),
  .stat_q      (stat_q)
);

// File: tb/test_scsi_dma_chan.sv
module test_scsi_dma_chan;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
  logic              stat_w1c = 1'b1;
  logic              xfer_req = 1'b0, xfer_dir = 1'b0;
  logic [LEN_W-1:0]  xfer_len = '0, xfer_len_out;
  logic              core_done = 1'b0, core_irq = 1'b0;
  logic              dma_en, abort_out;

  int checks = 0;
  int errors = 0;
  int sc_tab[6] = '{0, 1, 7, 128, 255, 300};

  always #4 clk = ~clk;

  scsi_dma_chan #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_scsi_dma_chan (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .stat_w1c_i(stat_w1c),
    .xfer_req_i(xfer_req), .xfer_dir_i(xfer_dir), .xfer_len_i(xfer_len),
    .xfer_len_o(xfer_len_out),
    .core_done_i(core_done), .core_irq_i(core_irq),
    .dma_en_o(dma_en), .abort_o(abort_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic xfer(input logic d, input logic [7:0] l, output logic [7:0] got);
    @(negedge clk);
    xfer_req = 1'b1; xfer_dir = d; xfer_len = l;
    #1 got = xfer_len_out;
    @(negedge clk);
    xfer_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  got;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R13 reset state
    rd(3'd0, v); chk("R13 cmd", v, 32'h0);
    rd(3'd3, v); chk("R13 wcnt", v, 32'h0);
    rd(3'd4, v); chk("R13 wadr", v, 32'hFFFF_FFFF);
    rd(3'd7, v); chk("R13 wdsc", v, 32'hFFFF_FFFD);
    rd(3'd5, v); chk("R13 stat", v, 32'h0);
    chk("R13 dma_en", dma_en, 0);
    chk("R13 abort", abort_out, 0);

    // R1 map and readback
    wr(3'd1, 32'h0000_1234);
    wr(3'd2, 32'h1000_0000);
    wr(3'd6, 32'h0000_ABCD);
    wr(3'd0, 32'hDEAD_00F4);
    rd(3'd1, v); chk("R1 scnt", v, 32'h0000_1234);
    rd(3'd2, v); chk("R1 sadr", v, 32'h1000_0000);
    rd(3'd6, v); chk("R1 sdsc", v, 32'h0000_ABCD);
    rd(3'd0, v); chk("R1 cmd", v, 32'hDEAD_00F4);

    // R12 working registers are read-only
    wr(3'd3, 32'h5); wr(3'd4, 32'h7); wr(3'd7, 32'h9);
    rd(3'd3, v); chk("R12 wcnt", v, 32'h0);
    rd(3'd4, v); chk("R12 wadr", v, 32'hFFFF_FFFF);
    rd(3'd7, v); chk("R12 wdsc", v, 32'hFFFF_FFFD);

    // R2 start
    wr(3'd0, 32'h83);
    chk("R2 dma_en", dma_en, 1);
    rd(3'd3, v); chk("R2 wcnt", v, 32'h1234);
    rd(3'd4, v); chk("R2 wadr", v, 32'h1000_0000);
    rd(3'd7, v); chk("R2 wdsc", v, 32'hABCD);

    // R4 opcodes
    wr(3'd0, 32'h81);
    chk("R4 flush dma_en", dma_en, 1);
    chk("R4 flush abort", abort_out, 0);
    wr(3'd0, 32'h82);
    chk("R4 abort high", abort_out, 1);
    @(negedge clk);
    chk("R4 abort one cycle", abort_out, 0);
    wr(3'd0, 32'h80);
    chk("R4 idle dma_en", dma_en, 0);

    // R5 wrong direction dropped
    wr(3'd1, 32'd100); wr(3'd2, 32'h200); wr(3'd0, 32'h83);
    xfer(1'b0, 8'd10, got);
    chk("R5 len", got, 0);
    rd(3'd3, v); chk("R5 wcnt", v, 32'd100);
    rd(3'd4, v); chk("R5 wadr", v, 32'h200);
    xfer(1'b1, 8'd10, got);
    chk("R5 matching len", got, 10);

    // R6/R7 sweep
    stat_w1c = 1'b1;
    for (int s = 0; s < 6; s++) begin
      wr(3'd1, sc_tab[s]);
      wr(3'd2, 32'h4000_0000 + s);
      for (int l = 0; l < 256; l++) begin
        int e;
        e = (l < sc_tab[s]) ? l : sc_tab[s];
        wr(3'd0, 32'h03);
        xfer(1'b0, l[7:0], got);
        chk("R6 len", got, e);
        rd(3'd3, v); chk("R6 wcnt", v, sc_tab[s] - e);
        rd(3'd4, v); chk("R6 wadr", v, 32'h4000_0000 + s + e);
        rd(3'd5, v);
        chk("R7 done", v[3], (e != 0 && sc_tab[s] == e) ? 1 : 0);
      end
    end

    // R7 two-step reaching zero
    wr(3'd1, 32'd10); wr(3'd0, 32'h03);
    xfer(1'b0, 8'd4, got);
    rd(3'd5, v); chk("R7 not yet", v[3], 0);
    xfer(1'b0, 8'd6, got);
    rd(3'd5, v); chk("R7 reached", v[3], 1);
    xfer(1'b0, 8'd5, got);
    chk("R7 zero count len", got, 0);

    // R3 start clears status
    wr(3'd0, 32'h03);
    rd(3'd5, v); chk("R3 cleared", v, 32'h0);

    // R8 completion
    wr(3'd1, 32'd50); wr(3'd0, 32'h03);
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
    rd(3'd3, v); chk("R8 wcnt", v, 32'h0);
    rd(3'd5, v); chk("R8 done", v[3], 1);

    // R9 write-one-to-clear
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R9 zero write keeps", v[3], 1);
    rd(3'd5, v); chk("R9 read keeps", v[3], 1);
    wr(3'd5, 32'h08);
    rd(3'd5, v); chk("R9 cleared", v[3], 0);

    // R10 clear-on-read
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
    stat_w1c = 1'b0;
    wr(3'd5, 32'h0E);
    rd(3'd5, v); chk("R10 write ignored", v[3], 1);
    rd(3'd5, v); chk("R10 read cleared", v[3], 0);

    // R11 interrupt mirror
    core_irq = 1'b1;
    rd(3'd5, v); chk("R11 irq set", v[4], 1);
    core_irq = 1'b0;
    rd(3'd5, v); chk("R11 irq not held", v[4], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule